// File: doc/BRIEF.md
# RGMII Transmit Clock Generator

This block derives the RGMII transmit clock from one of two source clocks. A source selector feeds a programmable integer divider. A fixed halving stage follows the divider and gives a square output with an exact 50% duty cycle. An enable gate then passes or blocks that output. A last stage gives a second copy of the clock, shifted in phase by a programmable number of quarter-period steps.

All logic runs on one fast reference clock, `clk_ref_i`. The two source clocks enter as sampled inputs. The block synchronizes them and detects their rising edges. The selected source advances the divider once per rising edge. The output period is therefore 2 × ratio × source period, counted in reference cycles.

A phase step lasts `STEP_CYC` reference cycles. When the reference clock runs at four times the output rate and `STEP_CYC` is 1, one step equals one quarter of the output period. With an 8 ns output period, the four delay codes then give 0, 2, 4 and 6 ns.

Top module: `rgmii_txclk_gen`

## Requirements
- R1: While `rst_i` is high, and on the first cycle after it falls, both `clk_div_o` and `clk_dly_o` are low.
- R2: `src_sel_i` = 0 selects `src_a_i` and `src_sel_i` = 1 selects `src_b_i`. The output period follows the period of the chosen source.
- R3: For `div_val_i` from 2 through 7, `clk_div_o` has a period of 2·N·P reference cycles and a high time of N·P cycles. Here N is the field value and P is the source period in reference cycles.
- R4: `div_val_i` values 0 and 1 both give a ratio of 1, so the period is 2·P. Neither value stalls the output.
- R5: A new value on `src_sel_i` takes effect only in a cycle where both synchronized sources are low. After the switch, the period follows the new source.
- R6: While `gate_en_i` is 0, `clk_div_o` and `clk_dly_o` stay low once any high phase already in progress has ended.
- R7: The gate changes state only during the low phase of the halved clock. Every high pulse of `clk_div_o` therefore lasts the full N·P cycles, even when `gate_en_i` toggles at arbitrary times.
- R8: With `dly_code_i` = c, the value of `clk_dly_o` in a cycle equals the value `clk_div_o` had c·`STEP_CYC` cycles earlier.
- R9: With `dly_code_i` = 0, `clk_dly_o` matches `clk_div_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Fast reference clock that samples the sources and steps the phase |
| rst_i | input | 1 | Synchronous active-high reset |
| src_a_i | input | 1 | Source clock chosen when the select is 0 |
| src_b_i | input | 1 | Source clock chosen when the select is 1 |
| src_sel_i | input | 1 | Source select |
| div_val_i | input | DIV_W (3) | Divide ratio; 0 and 1 bypass the divider |
| gate_en_i | input | 1 | Enable for the output clock |
| dly_code_i | input | DLY_W (2) | Number of phase steps applied to the delayed output |
| clk_div_o | output | 1 | Divided, halved and gated clock |
| clk_dly_o | output | 1 | `clk_div_o` shifted by the phase code |

## Verification
The hardest case to reach is the gate closing or opening near an edge of the halved clock. A design that cuts pulses short fails only when the enable changes while the clock is high. The bench reaches this case by toggling `gate_en_i` every 7 cycles while the output has a 24-cycle period. That rate lands enable changes in every phase position. The bench then checks the width of every complete high pulse. It switches the source while the output is running and sweeps every divide value and delay code, so the divider sees counter states above a newly lowered ratio.

// File: rtl/txclk_pkg.sv
package txclk_pkg;
  typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} src_e;

  function automatic logic [7:0] eff_ratio(input logic [7:0] field);
    return (field < 8'd2) ? 8'd1 : field;
  endfunction
endpackage

// File: rtl/txclk_src_sel.sv
module txclk_src_sel #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic src_a_i,
  input  logic src_b_i,
  input  logic sel_i,
  output logic tick_o,
  output logic cur_sel_o,
  output logic both_low_o
);
  import txclk_pkg::*;

  logic [1:0] raw;
  logic [1:0] lvl;
  logic [1:0] prev_q;
  src_e       cur_q;

  assign raw = {src_b_i, src_a_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    logic [SYNC_N-1:0] sh_q;
    always_ff @(posedge clk) begin
      if (rst) sh_q <= '0;
      else     sh_q <= {sh_q[SYNC_N-2:0], raw[g]};
    end
    assign lvl[g] = sh_q[SYNC_N-1];
  end

  assign both_low_o = ~|lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      cur_q  <= SRC_A;
    end else begin
      prev_q <= lvl;
      if ((src_e'(sel_i) != cur_q) && both_low_o) cur_q <= src_e'(sel_i);
    end
  end

  assign cur_sel_o = cur_q;
  assign tick_o    = lvl[cur_q] & ~prev_q[cur_q];
endmodule

// File: rtl/txclk_div_half.sv
module txclk_div_half #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             half_o,
  output logic [DIV_W-1:0] cnt_o
);
  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] cnt_q;
  logic             half_q;

  assign lim = (div_i < DIV_W'(2)) ? DIV_W'(1) : div_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q >= lim - DIV_W'(1)) begin
        cnt_q  <= '0;
        half_q <= ~half_q;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end

  assign half_o = half_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/txclk_gate.sv
module txclk_gate (
  input  logic clk,
  input  logic rst,
  input  logic half_i,
  input  logic en_i,
  output logic en_q_o,
  output logic gated_o
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst)          en_q <= 1'b0;
    else if (!half_i) en_q <= en_i;
  end

  assign en_q_o  = en_q;
  assign gated_o = half_i & en_q;
endmodule

// File: rtl/txclk_phase.sv
module txclk_phase #(
  parameter int DLY_W    = 2,
  parameter int STEP_CYC = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_in_i,
  input  logic [DLY_W-1:0] code_i,
  output logic             div_o,
  output logic             dly_o
);
  localparam int DEPTH = ((1 << DLY_W) - 1) * STEP_CYC;
  localparam int TAP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] line_q;
  logic [TAP_W-1:0] tap;

  assign tap = TAP_W'(int'(code_i) * STEP_CYC - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      div_o  <= 1'b0;
      dly_o  <= 1'b0;
    end else begin
      line_q <= {line_q[DEPTH-2:0], clk_in_i};
      div_o  <= clk_in_i;
      if (code_i == '0) dly_o <= clk_in_i;
      else              dly_o <= line_q[tap];
    end
  end
endmodule

// File: rtl/rgmii_txclk_gen.sv
module rgmii_txclk_gen #(
  parameter int DIV_W    = 3,
  parameter int DLY_W    = 2,
  parameter int STEP_CYC = 1,
  parameter int SYNC_N   = 2
) (
  input  logic             clk_ref_i,
  input  logic             rst_i,
  input  logic             src_a_i,
  input  logic             src_b_i,
  input  logic             src_sel_i,
  input  logic [DIV_W-1:0] div_val_i,
  input  logic             gate_en_i,
  input  logic [DLY_W-1:0] dly_code_i,
  output logic             clk_div_o,
  output logic             clk_dly_o
);
  logic             tick;
  logic             src_cur;
  logic             both_low;
  logic             half;
  logic [DIV_W-1:0] cnt;
  logic             en_q;
  logic             gated;

  txclk_src_sel #(.SYNC_N(SYNC_N)) u_sel (
    .clk(clk_ref_i), .rst(rst_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
    .sel_i(src_sel_i), .tick_o(tick), .cur_sel_o(src_cur), .both_low_o(both_low)
  );

  txclk_div_half #(.DIV_W(DIV_W)) u_div (
    .clk(clk_ref_i), .rst(rst_i), .tick_i(tick), .div_i(div_val_i),
    .half_o(half), .cnt_o(cnt)
  );

  txclk_gate u_gate (
    .clk(clk_ref_i), .rst(rst_i), .half_i(half), .en_i(gate_en_i),
    .en_q_o(en_q), .gated_o(gated)
  );

  txclk_phase #(.DLY_W(DLY_W), .STEP_CYC(STEP_CYC)) u_phase (
    .clk(clk_ref_i), .rst(rst_i), .clk_in_i(gated), .code_i(dly_code_i),
    .div_o(clk_div_o), .dly_o(clk_dly_o)
  );
endmodule

// File: rtl/rgmii_txclk_gen_chk.sv
module rgmii_txclk_gen_chk #(
  parameter int DIV_W = 3,
  parameter int DLY_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             src_cur,
  input logic             both_low,
  input logic             tick,
  input logic             half,
  input logic [DIV_W-1:0] cnt,
  input logic             en_q,
  input logic [DLY_W-1:0] dly_code,
  input logic             div_o,
  input logic             dly_o
);
  AST_RST_LOW: assert property (@(posedge clk) rst |=> (!div_o && !dly_o)); // R1
  AST_SEL_SAFE: assert property (@(posedge clk) disable iff (rst)
    (src_cur != $past(src_cur)) |-> $past(both_low)); // R5
  AST_HALF_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (half != $past(half)) |-> $past(tick)); // R3
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt != '1); // R4
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !div_o); // R6
  AST_GATE_LOWSWAP: assert property (@(posedge clk) disable iff (rst)
    (en_q != $past(en_q)) |-> !$past(half)); // R7
  AST_DLY_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(dly_code) == '0) |-> (dly_o == div_o)); // R9
endmodule

bind rgmii_txclk_gen rgmii_txclk_gen_chk #(.DIV_W(DIV_W), .DLY_W(DLY_W)) chk_i (
  .clk(clk_ref_i), .rst(rst_i), .src_cur(src_cur), .both_low(both_low),
  .tick(tick), .half(half), .cnt(cnt), .en_q(en_q), .dly_code(dly_code_i),
  .div_o(clk_div_o), .dly_o(clk_dly_o)
);

// File: tb/rgmii_txclk_gen_tb_top.sv
`timescale 1ns/1ps
module rgmii_txclk_gen_tb_top;
  localparam int STEP = 1;
  localparam int PA   = 4;
  localparam int PB   = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       src_a = 1'b0;
  logic       src_b = 1'b0;
  logic       sel = 1'b0;
  logic [2:0] div = 3'd2;
  logic       en = 1'b0;
  logic [1:0] code = 2'd0;
  logic       clk_div, clk_dly;
  int         ca = 0, cb = 0;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  rgmii_txclk_gen #(.STEP_CYC(STEP)) dut_i (
    .clk_ref_i(clk), .rst_i(rst), .src_a_i(src_a), .src_b_i(src_b),
    .src_sel_i(sel), .div_val_i(div), .gate_en_i(en), .dly_code_i(code),
    .clk_div_o(clk_div), .clk_dly_o(clk_dly)
  );

  always @(negedge clk) begin
    ca    <= (ca == PA - 1) ? 0 : ca + 1;
    cb    <= (cb == PB - 1) ? 0 : cb + 1;
    src_a <= (ca < PA / 2);
    src_b <= (cb < PB / 2);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(output int hi, output int per);
    logic p;
    int   lo, guard;
    hi = 0; lo = 0; guard = 0;
    @(negedge clk); p = clk_div;
    while (!(!p && clk_div) && guard < 500) begin
      p = clk_div; @(negedge clk); guard++;
    end
    while (clk_div && guard < 1000) begin hi++; @(negedge clk); guard++; end
    while (!clk_div && guard < 1500) begin lo++; @(negedge clk); guard++; end
    per = hi + lo;
  endtask

  function automatic int ratio(input int f);
    return (f < 2) ? 1 : f;
  endfunction

  initial begin : main
    int hi, per, n, p, miss, run, bad_w;
    logic rec[0:199];
    bit   in_run, seen_low;
    settle(3);
    chk(!clk_div && !clk_dly, "R1 in reset", int'(clk_div) + int'(clk_dly), 0);
    @(negedge clk); rst = 1'b0; en = 1'b1;
    @(negedge clk);
    chk(!clk_div && !clk_dly, "R1 after reset", int'(clk_div) + int'(clk_dly), 0);

    // R2 R3 R4: sweep both sources and all divide values
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 8; d++) begin
        sel = s[0]; div = 3'(d);
        settle(200);
        measure(hi, per);
        n = ratio(d); p = (s == 0) ? PA : PB;
        chk(per == 2 * n * p && hi == n * p,
            (d < 2) ? "R4 bypass period" : (s == 0 ? "R3 period src A R2" : "R3 period src B R2"),
            per * 1000 + hi, 2 * n * p * 1000 + n * p);
      end
    end

    // R5: live switch B -> A, then period follows A
    div = 3'd3; sel = 1'b1; settle(150);
    sel = 1'b0; settle(150);
    measure(hi, per);
    chk(per == 2 * 3 * PA, "R5 switch to A", per, 2 * 3 * PA);

    // R8 R9: every delay code
    div = 3'd2;
    for (int c = 0; c < 4; c++) begin
      code = 2'(c); settle(60);
      miss = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        rec[i] = clk_div;
        if (i >= c * STEP && clk_dly !== rec[i - c * STEP]) miss++;
      end
      chk(miss == 0, (c == 0) ? "R9 zero delay" : "R8 delay code", miss, 0);
    end
    code = 2'd0;

    // R7: toggle enable at arbitrary phases, all high pulses full width
    div = 3'd3; sel = 1'b0; settle(100);
    run = 0; in_run = 0; seen_low = 0; bad_w = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (i % 7 == 0) en = ~en;
      if (clk_div) begin
        if (seen_low) begin in_run = 1; run++; end
      end else begin
        if (in_run && run != 3 * PA) bad_w++;
        in_run = 0; run = 0; seen_low = 1;
      end
    end
    chk(bad_w == 0, "R7 pulse width", bad_w, 0);

    // R6: gate closed holds outputs low
    en = 1'b0; code = 2'd2; settle(60);
    miss = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (clk_div || clk_dly) miss++;
    end
    chk(miss == 0, "R6 gate closed", miss, 0);
    en = 1'b1; settle(60);
    measure(hi, per);
    chk(per == 2 * 3 * PA, "R6 gate reopened", per, 2 * 3 * PA);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule